// File: doc/BRIEF.md
# Low-Frequency Carrier Modulator

The block produces the square-wave drive for a low-frequency antenna from a divided system clock. It keys that carrier from the level of a single-wire data line. It serves as the modulation stage that follows the command interface. A pulse on `mod_start_i` marks the end of a command and puts the block in modulation mode. While that mode is active, the line either gates the carrier on and off (amplitude keying) or flips its phase by half a period on every line transition (phase keying). The block leaves modulation mode by itself when the line has been quiet for the selected timeout.

The carrier period has eight equal sub-phases. The upper two bits of the coil-current code set the high time to one, two, three or four of them. Changes to the gate, the duty and the phase take effect only at a period boundary, so the driver never sees a runt pulse. The quick-start switch gate follows the carrier gate at the same boundaries, which stand in for the antenna-current zero crossings. A carrier started by a wake-up runs in command mode until the next modulation mode begins. It is not restored when the block returns from that mode. A fault shuts off both drive outputs but leaves the mode timing running.

Top module: `lf_carrier_mod`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `carrier_o`, `qsc_o` and `mod_active_o` are 0.
- R2: In amplitude mode (`psk_mode_i`=0) with the carrier enabled in modulation mode, a high synchronized line level gives a running carrier and a low level gives no carrier. The change is applied at the next period boundary.
- R3: In phase mode (`psk_mode_i`=1), each transition of the line shifts the carrier waveform by half a period, four sub-phases. Two transitions restore the original phase.
- R4: In modulation mode with `carrier_en_i`=0, the carrier stays off whatever the line does.
- R5: The carrier is high for (`coil_code_i[3:2]`+1) of every eight sub-phases. Each sub-phase lasts SUB_DIV clocks, so the duty runs from 12.5 % to 50 %.
- R6: Modulation mode ends exactly TMO cycles after the clock in which a line edge was detected. TMO is TMO_SHORT_CYC when `tmo_short_i` was 1 at the mode start and TMO_LONG_CYC otherwise. `mod_active_o` falls after the edge of clock number TMO+3 counted from the line change, because two synchronizer stages and one reload register sit in the path.
- R7: Each detected line edge during modulation mode reloads the timeout, so a line that keeps toggling keeps the mode active indefinitely.
- R8: A `wake_carrier_i` pulse runs the carrier in command mode. A `mod_start_i` pulse cancels this, and the carrier stays off in command mode after modulation mode ends.
- R9: A `fault_i` pulse forces `carrier_o` and `qsc_o` to 0 until the next `mod_start_i`. The mode timeout keeps running and still ends the mode.
- R10: `qsc_o` is 1 for exactly the periods in which the carrier is gated on and no fault is held. Its gate part changes only at a period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Asynchronous single-wire data line level |
| mod_start_i | input | 1 | One-cycle pulse: enter modulation mode |
| carrier_en_i | input | 1 | Carrier enable configuration bit |
| psk_mode_i | input | 1 | 0 = amplitude keying, 1 = phase keying |
| tmo_short_i | input | 1 | 1 = short inactivity timeout, sampled at mode start |
| coil_code_i | input | 4 | Coil-current code; bits 3:2 set the duty |
| wake_carrier_i | input | 1 | One-cycle pulse: carrier on after wake-up |
| fault_i | input | 1 | Fault detected; shuts off the drive outputs |
| carrier_o | output | 1 | Carrier drive to the half bridge |
| qsc_o | output | 1 | Quick-start switch gate |
| mod_active_o | output | 1 | Modulation mode active |

## Verification
The bench measures the high-cycle count over a whole period for each duty step. A decode that took the wrong code bits, or added no offset of one, would give a count off by a multiple of SUB_DIV. For phase keying it captures a period before and after one line transition and after two transitions. A design that inverted the level instead of rotating it, or that toggled only on rising edges, would break the half-period swap or the restore. It finds the exact cycle where the timeout ends, for both lengths and under repeated reloads, so an off-by-one or a counter that failed to reload shows up directly. It also checks that a wake-up carrier does not survive a round trip through modulation mode, and that a held fault neither shuts down the mode early nor outlives the next start.

// File: rtl/lfm_pkg.sv
`timescale 1ns/1ps
package lfm_pkg;
  localparam int PH_N = 8;
  typedef logic [2:0] phase_t;
  typedef logic [2:0] duty_t;

  // high sub-phases per period: 1..4 from the upper code bits
  function automatic duty_t duty_from_code(input logic [3:0] code);
    return duty_t'({1'b0, code[3:2]}) + duty_t'(1);
  endfunction

  // half-period rotation for phase inversion
  function automatic logic wave_at(input phase_t ph, input duty_t duty, input logic inv);
    phase_t p;
    p = inv ? (ph ^ 3'b100) : ph;
    return (p < duty);
  endfunction
endpackage

// File: rtl/lfm_line_sync.sv
`timescale 1ns/1ps
module lfm_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign edge_o  = s2_q ^ prev_q;
endmodule

// File: rtl/lfm_phase_gen.sv
`timescale 1ns/1ps
module lfm_phase_gen #(
  parameter int SUB_DIV = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  output lfm_pkg::phase_t ph_o,
  output logic           boundary_o
);
  import lfm_pkg::*;
  localparam int SW = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;
  localparam logic [SW-1:0] SUB_LAST = SW'(SUB_DIV - 1);

  logic [SW-1:0] sub_q;
  phase_t        ph_q;
  logic          sub_wrap;

  assign sub_wrap = (sub_q == SUB_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      ph_q  <= '0;
    end else if (sub_wrap) begin
      sub_q <= '0;
      ph_q  <= ph_q + phase_t'(1);
    end else begin
      sub_q <= sub_q + SW'(1);
    end
  end

  assign ph_o       = ph_q;
  assign boundary_o = sub_wrap && (ph_q == phase_t'(PH_N - 1));

  // R5
  sub_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(sub_q) < SUB_DIV);
endmodule

// File: rtl/lfm_timeout.sv
`timescale 1ns/1ps
module lfm_timeout #(
  parameter int TMO_LONG_CYC  = 16000,
  parameter int TMO_SHORT_CYC = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic edge_i,
  input  logic short_i,
  output logic active_o,
  output logic expire_o
);
  localparam int MAXC = (TMO_LONG_CYC > TMO_SHORT_CYC) ? TMO_LONG_CYC : TMO_SHORT_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q, lim;
  logic          active_q, short_q;

  assign lim      = short_q ? CW'(TMO_SHORT_CYC) : CW'(TMO_LONG_CYC);
  assign expire_o = active_q && !start_i && !edge_i && (cnt_q >= lim - CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      short_q  <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
      short_q  <= short_i;
    end else if (active_q && edge_i) begin
      cnt_q <= '0;
    end else if (expire_o) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (active_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign active_o = active_q;

  // R6
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < lim));
  // R7
  edge_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && edge_i) |=> (active_q && cnt_q == '0));
endmodule

// File: rtl/lf_carrier_mod.sv
`timescale 1ns/1ps
module lf_carrier_mod #(
  parameter int SUB_DIV       = 8,
  parameter int TMO_LONG_CYC  = 16000,
  parameter int TMO_SHORT_CYC = 4000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  logic       mod_start_i,
  input  logic       carrier_en_i,
  input  logic       psk_mode_i,
  input  logic       tmo_short_i,
  input  logic [3:0] coil_code_i,
  input  logic       wake_carrier_i,
  input  logic       fault_i,
  output logic       carrier_o,
  output logic       qsc_o,
  output logic       mod_active_o
);
  import lfm_pkg::*;

  logic   line_lvl, line_edge;
  logic   mod_active, tmo_expire;
  phase_t ph;
  logic   boundary;

  logic   wake_hold_q, fault_q, psk_ph_q;
  logic   gate_q, inv_q;
  duty_t  duty_q;
  logic   gate_next;

  lfm_line_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (line_i),
    .level_o (line_lvl),
    .edge_o  (line_edge)
  );

  lfm_timeout #(
    .TMO_LONG_CYC  (TMO_LONG_CYC),
    .TMO_SHORT_CYC (TMO_SHORT_CYC)
  ) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (mod_start_i),
    .edge_i   (line_edge),
    .short_i  (tmo_short_i),
    .active_o (mod_active),
    .expire_o (tmo_expire)
  );

  lfm_phase_gen #(.SUB_DIV(SUB_DIV)) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ph_o       (ph),
    .boundary_o (boundary)
  );

  assign gate_next = wake_hold_q ||
                     (mod_active && carrier_en_i && (psk_mode_i || line_lvl));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_hold_q <= 1'b0;
      fault_q     <= 1'b0;
      psk_ph_q    <= 1'b0;
    end else begin
      if (mod_start_i)         wake_hold_q <= 1'b0;
      else if (wake_carrier_i) wake_hold_q <= 1'b1;

      if (mod_start_i)  fault_q <= 1'b0;
      else if (fault_i) fault_q <= 1'b1;

      if (mod_start_i)
        psk_ph_q <= 1'b0;
      else if (mod_active && psk_mode_i && line_edge)
        psk_ph_q <= ~psk_ph_q;
    end
  end

  // gate, duty and phase are taken only at a period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      inv_q  <= 1'b0;
      duty_q <= duty_t'(1);
    end else if (boundary) begin
      gate_q <= gate_next;
      inv_q  <= psk_ph_q;
      duty_q <= duty_from_code(coil_code_i);
    end
  end

  assign carrier_o    = gate_q && !fault_q && wave_at(ph, duty_q, inv_q);
  assign qsc_o        = gate_q && !fault_q;
  assign mod_active_o = mod_active;

  // R10
  gate_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gate_q) |-> $past(boundary));
  // R8
  wake_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mod_start_i |=> !wake_hold_q);
  // R9
  fault_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && mod_active && !tmo_expire && !mod_start_i) |=> mod_active);
  // R4
  no_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary && mod_active && !carrier_en_i && !wake_hold_q) |=> !gate_q);
endmodule

// File: tb/lf_carrier_mod_test.sv
`timescale 1ns/1ps
module lf_carrier_mod_test;
  localparam int SUB  = 2;
  localparam int PER  = 8 * SUB;
  localparam int LONG = 200;
  localparam int SHRT = 60;
  localparam int NV   = 8;
  // duty table: coil code -> expected high cycles per period
  localparam logic [3:0] CODE_V [NV] = '{4'd0, 4'd3, 4'd4, 4'd7, 4'd8, 4'd11, 4'd12, 4'd15};
  localparam int         HIGH_V [NV] = '{2, 2, 4, 4, 6, 6, 8, 8};

  logic clk = 1'b0, rst_n = 1'b0;
  logic line = 1'b1, start = 1'b0, cen = 1'b0, psk = 1'b0, shrt = 1'b0;
  logic [3:0] code = 4'd15;
  logic wake = 1'b0, fault = 1'b0;
  logic carrier, qsc, active;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lf_carrier_mod #(.SUB_DIV(SUB), .TMO_LONG_CYC(LONG), .TMO_SHORT_CYC(SHRT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .mod_start_i(start),
    .carrier_en_i(cen), .psk_mode_i(psk), .tmo_short_i(shrt), .coil_code_i(code),
    .wake_carrier_i(wake), .fault_i(fault), .carrier_o(carrier), .qsc_o(qsc),
    .mod_active_o(active)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(output int c);
    c = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (carrier) c++;
    end
  endtask

  task automatic capture(output logic [PER-1:0] v);
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      v[i] = carrier;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int c;
    logic [PER-1:0] a, b, d;

    // R1 reset state
    wait_n(3);
    chk("R1 carrier in reset", carrier, 0);
    chk("R1 qsc in reset", qsc, 0);
    rst_n = 1'b1;
    wait_n(40);
    chk("R1 carrier idle", carrier, 0);
    chk("R1 active idle", active, 0);

    // R5 duty table under wake carrier (R8)
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
    for (int i = 0; i < NV; i++) begin
      code = CODE_V[i];
      wait_n(2 * PER);
      count_high(c);
      chk($sformatf("R5 duty code %0d", CODE_V[i]), c, HIGH_V[i]);
    end
    chk("R10 qsc on with wake carrier", qsc, 1);

    // R4 / R8: start with enable off cancels wake carrier
    cen = 1'b0;
    pulse_start();
    wait_n(2 * PER);
    count_high(c);
    chk("R4 R8 no carrier with enable off", c, 0);
    chk("R6 mode active", active, 1);
    wait_n(LONG + 20);
    chk("R6 mode ended", active, 0);
    count_high(c);
    chk("R8 wake carrier not restored", c, 0);

    // R2 amplitude keying
    cen = 1'b1; psk = 1'b0; code = 4'd15; line = 1'b1;
    pulse_start();
    wait_n(2 * PER);
    count_high(c);
    chk("R2 ask line high", c, 8);
    chk("R10 qsc line high", qsc, 1);
    line = 1'b0;
    wait_n(2 * PER);
    count_high(c);
    chk("R2 ask line low", c, 0);
    chk("R10 qsc line low", qsc, 0);
    line = 1'b1;
    wait_n(2 * PER);
    count_high(c);
    chk("R2 ask line high again", c, 8);

    // R6 exact long timeout
    @(negedge clk); line = ~line;
    wait_n(LONG + 2);
    chk("R6 long still active", active, 1);
    wait_n(1);
    chk("R6 long expired", active, 0);

    // R6 exact short timeout
    shrt = 1'b1;
    pulse_start();
    wait_n(3);
    @(negedge clk); line = ~line;
    wait_n(SHRT + 2);
    chk("R6 short still active", active, 1);
    wait_n(1);
    chk("R6 short expired", active, 0);

    // R7 reload keeps mode alive
    pulse_start();
    for (int i = 0; i < 5; i++) begin
      wait_n(40);
      line = ~line;
    end
    wait_n(SHRT + 2);
    chk("R7 toggling keeps mode", active, 1);
    wait_n(1);
    chk("R7 expires after last edge", active, 0);

    // R3 phase keying
    shrt = 1'b0; psk = 1'b1; code = 4'd0; cen = 1'b1;
    pulse_start();
    wait_n(2 * PER);
    capture(a);
    line = ~line;
    wait_n(2 * PER);
    capture(b);
    chk("R3 carrier running", int'(a != '0), 1);
    chk("R3 half period shift", int'(b), int'({a[PER/2-1:0], a[PER-1:PER/2]}));
    line = ~line;
    wait_n(5);
    line = ~line;
    wait_n(2 * PER - 5);
    capture(d);
    chk("R3 two edges keep phase", int'(d), int'(b));

    // R9 fault
    wait_n(LONG + 20);
    chk("R6 psk mode ended", active, 0);
    psk = 1'b0; code = 4'd15;
    if (!line) line = 1'b1;
    wait_n(5);
    pulse_start();
    wait_n(2 * PER);
    count_high(c);
    chk("R9 carrier before fault", c, 8);
    @(negedge clk); fault = 1'b1;
    @(negedge clk); fault = 1'b0;
    wait_n(2);
    count_high(c);
    chk("R9 carrier off after fault", c, 0);
    chk("R9 qsc off after fault", qsc, 0);
    chk("R9 mode continues", active, 1);
    wait_n(LONG + 20);
    chk("R9 timeout still ends mode", active, 0);
    pulse_start();
    wait_n(2 * PER);
    count_high(c);
    chk("R9 fault cleared by start", c, 8);

    finish_run();
  end
endmodule